// File: doc/BRIEF.md
# Multi-Mode Capture/Compare Timer Array

This block gives a set of channels one shared free-running counter that advances on a clock-enable strobe. Each channel has its own compare/capture register and output line, and software picks the channel's operating mode separately for each channel. The five modes are:

- snapshotting the counter on an input edge;
- raising a flag on a count match;
- toggling an output on a match;
- generating a square wave with a programmable half-period;
- producing an edge-aligned PWM waveform whose resolution is selectable.

The host programs the block through dedicated write strobes for the counter, for each channel's configuration byte and for each channel's compare value. It watches the state through registered read-back outputs. Each channel has a sticky event flag, and the shared counter has one overflow flag. Software clears every flag through a write-one strobe.

Top module: `pca_timer_array`

## Requirements
- R1: After reset the counter is 0. It advances by one on each clock where `tick` is high and wraps from 0xFFFF to 0. A `cnt_wr` strobe loads `cnt_wdata` and takes priority over counting.
- R2: `ovf_flag` sets on a clock where the counter counts past 0xFFFF. It stays set until `ovf_clr` is pulsed. When a wrap and a clear happen in the same clock, the flag stays set.
- R3: In capture mode (mode code 1), configuration bits [4:3] select the edge: 01 is rising, 10 is falling and 11 is either. On the clock where the selected edge of `cap_in` is seen, the channel's register takes the current counter value and its flag sets.
- R4: In software-timer mode (mode code 2), the flag sets on a `tick` clock where the counter equals the compare value. The channel output does not change.
- R5: In toggle-on-match mode (mode code 3), the output inverts and the flag sets on each `tick` clock where the counter equals the full 16-bit compare value.
- R6: In square-wave mode (mode code 4), on a `tick` clock where the counter's low byte equals the compare high byte, three things happen: the output inverts, the flag sets, and the compare low byte is added (mod 256) to the compare high byte.
- R7: In PWM mode (mode code 5), configuration bits [7:5] select the resolution N: 0 gives 8, 1 gives 9, 2 gives 10, 3 gives 11, and any higher code gives 16. On a `tick` clock where the low N counter bits are all ones, the output goes high. Otherwise, on a `tick` clock where the low N bits equal the active compare value, the output goes low and the flag sets.
- R8: In PWM mode the active compare value is the low N bits of the compare register. It is copied only on the clock where the output goes high, so a compare write in the middle of a period takes effect in the next period.
- R9: Channel flags stay set until that channel's `flag_clr` bit is pulsed, and a new event in the same clock wins over the clear. A configuration write sets the channel output to 0.
- R10: After reset, all configuration, compare values, outputs and flags are 0. With mode code 0 (off) a channel changes only when software writes its compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| cfg_wr | input | NUM_CH | Per-channel configuration write strobe |
| cfg_wdata | input | 8 | Configuration byte: [7:5] PWM size, [4:3] edge select, [2:0] mode |
| cmp_wr | input | NUM_CH | Per-channel compare write strobe |
| cmp_wdata | input | CNT_W | Compare write value |
| flag_clr | input | NUM_CH | Per-channel flag clear |
| ovf_clr | input | 1 | Overflow flag clear |
| cap_in | input | NUM_CH | Capture inputs |
| cnt_val | output | CNT_W | Counter value |
| cmp_val | output | NUM_CH*CNT_W | Compare/capture registers, channel 0 in the low bits |
| ch_out | output | NUM_CH | Channel waveform outputs |
| ch_flag | output | NUM_CH | Channel event flags |
| ovf_flag | output | 1 | Counter wrap flag |

## Verification
The bench uses the defaults: a 16-bit counter and three channels. With these values every PWM resolution and a full 16-bit wrap are in reach. A counter load near 0xF000 lets 16-bit PWM, the overflow flag and the clear-versus-wrap collision all happen within a few thousand cycles. The three channels can run three different modes at once, and the capture test uses them to run all three edge selections side by side. A behavioural model checks every output on every clock.

// File: rtl/pca_pkg.sv
package pca_pkg;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_CAPT = 3'd1,
    MODE_SWT  = 3'd2,
    MODE_HSO  = 3'd3,
    MODE_FREQ = 3'd4,
    MODE_PWM  = 3'd5
  } pca_mode_e;

  // byte layout: [7:5] pwm size code, [4:3] edge select, [2:0] mode
  typedef struct packed {
    logic [2:0] pwm_sz;
    logic [1:0] edge_sel;
    pca_mode_e  mode;
  } pca_cfg_t;

  localparam int CFG_W = 8;

endpackage

// File: rtl/pca_timebase.sv
module pca_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  logic wrap;
  assign wrap = tick && !load && (&cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (load)      cnt <= load_val;
      else if (tick) cnt <= cnt + 1'b1;
      ovf <= wrap | (ovf & ~ovf_clr);
    end
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> (cnt == $past(cnt) + 1'b1));

  assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt));

  assert_wrap_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && (cnt == {CNT_W{1'b1}})) |=> ovf);

  assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

endmodule

// File: rtl/pca_edge_detect.sv
module pca_edge_detect #(
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CH-1:0]   sig_in,
  input  logic [2*NUM_CH-1:0] edge_sel,
  output logic [NUM_CH-1:0]   evt
);

  logic [NUM_CH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= sig_in;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_edge
    logic rise, fall;
    assign rise   = sig_in[g] & ~prev[g];
    assign fall   = ~sig_in[g] & prev[g];
    assign evt[g] = (edge_sel[2*g] & rise) | (edge_sel[2*g+1] & fall);
  end

endmodule

// File: rtl/pca_channel.sv
module pca_channel
  import pca_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cfg_wr,
  input  pca_cfg_t         cfg_in,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             flag_clr,
  input  logic             cap_evt,
  output logic [1:0]       edge_sel,
  output logic [CNT_W-1:0] cmp,
  output logic             out,
  output logic             flag
);

  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONES    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] MASK_8  = ONES >> (CNT_W - 8);
  localparam logic [CNT_W-1:0] MASK_9  = ONES >> (CNT_W - 9);
  localparam logic [CNT_W-1:0] MASK_10 = ONES >> (CNT_W - 10);
  localparam logic [CNT_W-1:0] MASK_11 = ONES >> (CNT_W - 11);

  pca_cfg_t         cfg;
  logic [CNT_W-1:0] act;
  logic [CNT_W-1:0] pwm_mask;
  logic [CNT_W-1:0] low_cnt;
  logic [CNT_W-1:0] cmp_n, act_n;
  logic             out_n, hit;

  assign edge_sel = cfg.edge_sel;

  always_comb begin
    case (cfg.pwm_sz)
      3'd0:    pwm_mask = MASK_8;
      3'd1:    pwm_mask = MASK_9;
      3'd2:    pwm_mask = MASK_10;
      3'd3:    pwm_mask = MASK_11;
      default: pwm_mask = ONES;
    endcase
  end

  assign low_cnt = cnt & pwm_mask;

  always_comb begin
    cmp_n = cmp;
    act_n = act;
    out_n = out;
    hit   = 1'b0;
    case (cfg.mode)
      MODE_CAPT: begin
        if (cap_evt) begin
          cmp_n = cnt;
          hit   = 1'b1;
        end
      end
      MODE_SWT: begin
        if (tick && cnt == cmp) hit = 1'b1;
      end
      MODE_HSO: begin
        if (tick && cnt == cmp) begin
          hit   = 1'b1;
          out_n = ~out;
        end
      end
      MODE_FREQ: begin
        if (tick && cnt[HALF-1:0] == cmp[CNT_W-1:HALF]) begin
          hit   = 1'b1;
          out_n = ~out;
          cmp_n[CNT_W-1:HALF] = cmp[CNT_W-1:HALF] + cmp[HALF-1:0];
        end
      end
      MODE_PWM: begin
        if (tick) begin
          if (low_cnt == pwm_mask) begin
            out_n = 1'b1;
            act_n = cmp & pwm_mask;
          end else if (low_cnt == act) begin
            out_n = 1'b0;
            hit   = 1'b1;
          end
        end
      end
      default: ;
    endcase
    if (cmp_wr) cmp_n = cmp_in;
    if (cfg_wr) out_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg  <= '0;
      cmp  <= '0;
      act  <= '0;
      out  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (cfg_wr) cfg <= cfg_in;
      cmp  <= cmp_n;
      act  <= act_n;
      out  <= out_n;
      flag <= hit | (flag & ~flag_clr);
    end
  end

  assert_capture_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_CAPT && cap_evt) |=> flag);

  assert_swt_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_SWT && !cfg_wr) |=> (out == $past(out)));

  assert_hso_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_HSO && tick && cnt == cmp && !cfg_wr) |=> (out != $past(out)));

  assert_freq_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_FREQ && tick && cnt[HALF-1:0] == cmp[CNT_W-1:HALF] && !cfg_wr)
      |=> (out != $past(out)));

  assert_pwm_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_PWM && tick && low_cnt == pwm_mask && !cfg_wr) |=> out);

  assert_pwm_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(cfg.mode == MODE_PWM && tick && low_cnt == pwm_mask) |=> $stable(act));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_clr) |=> flag);

  assert_cfg_clears_out_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !out);

  assert_off_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_OFF && !cfg_wr && !cmp_wr) |=> ($stable(cmp) && $stable(out)));

endmodule

// File: rtl/pca_timer_array.sv
module pca_timer_array
  import pca_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick,
  input  logic                    cnt_wr,
  input  logic [CNT_W-1:0]        cnt_wdata,
  input  logic [NUM_CH-1:0]       cfg_wr,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic [NUM_CH-1:0]       cmp_wr,
  input  logic [CNT_W-1:0]        cmp_wdata,
  input  logic [NUM_CH-1:0]       flag_clr,
  input  logic                    ovf_clr,
  input  logic [NUM_CH-1:0]       cap_in,
  output logic [CNT_W-1:0]        cnt_val,
  output logic [NUM_CH*CNT_W-1:0] cmp_val,
  output logic [NUM_CH-1:0]       ch_out,
  output logic [NUM_CH-1:0]       ch_flag,
  output logic                    ovf_flag
);

  logic [2*NUM_CH-1:0] edge_sel;
  logic [NUM_CH-1:0]   cap_evt;
  pca_cfg_t            cfg_word;

  assign cfg_word = pca_cfg_t'(cfg_wdata);

  pca_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (cnt_wr),
    .load_val (cnt_wdata),
    .ovf_clr  (ovf_clr),
    .cnt      (cnt_val),
    .ovf      (ovf_flag)
  );

  pca_edge_detect #(.NUM_CH(NUM_CH)) i_edges (
    .clk      (clk),
    .rst      (rst),
    .sig_in   (cap_in),
    .edge_sel (edge_sel),
    .evt      (cap_evt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pca_channel #(.CNT_W(CNT_W)) i_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .cnt      (cnt_val),
      .cfg_wr   (cfg_wr[g]),
      .cfg_in   (cfg_word),
      .cmp_wr   (cmp_wr[g]),
      .cmp_in   (cmp_wdata),
      .flag_clr (flag_clr[g]),
      .cap_evt  (cap_evt[g]),
      .edge_sel (edge_sel[2*g +: 2]),
      .cmp      (cmp_val[g*CNT_W +: CNT_W]),
      .out      (ch_out[g]),
      .flag     (ch_flag[g])
    );
  end

endmodule

// File: tb/test_pca_timer_array.sv
module test_pca_timer_array;

  localparam int CNT_W  = 16;
  localparam int NUM_CH = 3;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    tick = 1'b0;
  logic                    cnt_wr = 1'b0;
  logic [CNT_W-1:0]        cnt_wdata = '0;
  logic [NUM_CH-1:0]       cfg_wr = '0;
  logic [7:0]              cfg_wdata = '0;
  logic [NUM_CH-1:0]       cmp_wr = '0;
  logic [CNT_W-1:0]        cmp_wdata = '0;
  logic [NUM_CH-1:0]       flag_clr = '0;
  logic                    ovf_clr = 1'b0;
  logic [NUM_CH-1:0]       cap_in = '0;
  logic [CNT_W-1:0]        cnt_val;
  logic [NUM_CH*CNT_W-1:0] cmp_val;
  logic [NUM_CH-1:0]       ch_out;
  logic [NUM_CH-1:0]       ch_flag;
  logic                    ovf_flag;

  always #2 clk = ~clk;

  pca_timer_array #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) i_pca_timer_array (
    .clk(clk), .rst(rst), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .flag_clr(flag_clr), .ovf_clr(ovf_clr), .cap_in(cap_in), .cnt_val(cnt_val),
    .cmp_val(cmp_val), .ch_out(ch_out), .ch_flag(ch_flag), .ovf_flag(ovf_flag)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  int m_cnt, m_ovf;
  int m_cmp[NUM_CH], m_act[NUM_CH], m_out[NUM_CH], m_flag[NUM_CH];
  int m_mode[NUM_CH], m_edge[NUM_CH], m_psz[NUM_CH], m_prev[NUM_CH];
  int n_cnt, n_ovf;
  int n_cmp[NUM_CH], n_act[NUM_CH], n_out[NUM_CH], n_flag[NUM_CH];
  int n_mode[NUM_CH], n_edge[NUM_CH], n_psz[NUM_CH], n_prev[NUM_CH];

  function automatic int mask_of(int psz);
    case (psz)
      0: return 'hFF;
      1: return 'h1FF;
      2: return 'h3FF;
      3: return 'h7FF;
      default: return 'hFFFF;
    endcase
  endfunction

  function automatic string tag_of(int mode);
    case (mode)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7 R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_next();
    if (rst) begin
      n_cnt = 0; n_ovf = 0;
      for (int c = 0; c < NUM_CH; c++) begin
        n_cmp[c] = 0; n_act[c] = 0; n_out[c] = 0; n_flag[c] = 0;
        n_mode[c] = 0; n_edge[c] = 0; n_psz[c] = 0; n_prev[c] = 0;
      end
      return;
    end
    n_cnt = cnt_wr ? int'(cnt_wdata) : (tick ? ((m_cnt + 1) & 'hFFFF) : m_cnt);
    n_ovf = ((tick && !cnt_wr && m_cnt == 'hFFFF) || (m_ovf && !ovf_clr)) ? 1 : 0;
    for (int c = 0; c < NUM_CH; c++) begin
      int ev, mk, lo;
      ev = 0;
      n_cmp[c] = m_cmp[c]; n_act[c] = m_act[c]; n_out[c] = m_out[c];
      n_mode[c] = m_mode[c]; n_edge[c] = m_edge[c]; n_psz[c] = m_psz[c];
      case (m_mode[c])
        1: begin
          if (((m_edge[c] & 1) != 0 && cap_in[c] && m_prev[c] == 0) ||
              ((m_edge[c] & 2) != 0 && !cap_in[c] && m_prev[c] == 1)) begin
            n_cmp[c] = m_cnt; ev = 1;
          end
        end
        2: if (tick && m_cnt == m_cmp[c]) ev = 1;
        3: if (tick && m_cnt == m_cmp[c]) begin ev = 1; n_out[c] = 1 - m_out[c]; end
        4: if (tick && (m_cnt & 'hFF) == (m_cmp[c] >> 8)) begin
          ev = 1; n_out[c] = 1 - m_out[c];
          n_cmp[c] = ((((m_cmp[c] >> 8) + (m_cmp[c] & 'hFF)) & 'hFF) << 8) | (m_cmp[c] & 'hFF);
        end
        5: if (tick) begin
          mk = mask_of(m_psz[c]);
          lo = m_cnt & mk;
          if (lo == mk) begin n_out[c] = 1; n_act[c] = m_cmp[c] & mk; end
          else if (lo == m_act[c]) begin n_out[c] = 0; ev = 1; end
        end
        default: ;
      endcase
      if (cmp_wr[c]) n_cmp[c] = cmp_wdata;
      n_flag[c] = (ev || (m_flag[c] && !flag_clr[c])) ? 1 : 0;
      if (cfg_wr[c]) begin
        n_out[c]  = 0;
        n_mode[c] = cfg_wdata[2:0];
        n_edge[c] = cfg_wdata[4:3];
        n_psz[c]  = cfg_wdata[7:5];
      end
      n_prev[c] = cap_in[c];
    end
  endtask

  task automatic cycle();
    model_next();
    @(posedge clk);
    #1;
    m_cnt = n_cnt; m_ovf = n_ovf;
    for (int c = 0; c < NUM_CH; c++) begin
      m_cmp[c] = n_cmp[c]; m_act[c] = n_act[c]; m_out[c] = n_out[c]; m_flag[c] = n_flag[c];
      m_mode[c] = n_mode[c]; m_edge[c] = n_edge[c]; m_psz[c] = n_psz[c]; m_prev[c] = n_prev[c];
    end
    check("R1", "counter", int'(cnt_val), m_cnt);
    check("R2", "overflow flag", int'(ovf_flag), m_ovf);
    for (int c = 0; c < NUM_CH; c++) begin
      check(tag_of(m_mode[c]), $sformatf("ch%0d compare", c), int'(cmp_val[c*CNT_W +: CNT_W]), m_cmp[c]);
      check(tag_of(m_mode[c]), $sformatf("ch%0d output", c), int'(ch_out[c]), m_out[c]);
      check("R9", $sformatf("ch%0d flag", c), int'(ch_flag[c]), m_flag[c]);
    end
  endtask

  task automatic run(int n, int tick_mode);
    for (int i = 0; i < n; i++) begin
      tick = (tick_mode == 1) ? 1'b1 : 1'($urandom % 2);
      cycle();
    end
  endtask

  task automatic put_cfg(int ch, int psz, int edge_s, int mode);
    cfg_wdata = 8'((psz << 5) | (edge_s << 3) | mode);
    cfg_wr[ch] = 1'b1;
    cycle();
    cfg_wr = '0;
  endtask

  task automatic put_cmp(int ch, int val);
    cmp_wdata = 16'(val);
    cmp_wr[ch] = 1'b1;
    cycle();
    cmp_wr = '0;
  endtask

  task automatic put_cnt(int val);
    cnt_wdata = 16'(val);
    cnt_wr = 1'b1;
    cycle();
    cnt_wr = 1'b0;
  endtask

  initial begin
    // reset: everything zero (R10)
    for (int i = 0; i < 4; i++) cycle();
    rst = 1'b0;
    check("R10", "reset counter", int'(cnt_val), 0);
    check("R10", "reset outputs", int'(ch_out), 0);
    check("R10", "reset flags", int'({ch_flag, ovf_flag}), 0);

    // R1: random ticks; R10: off-mode channel only changes by write
    run(120, 0);
    put_cmp(0, 'h1234);
    run(40, 0);
    check("R10", "off channel keeps compare", int'(cmp_val[CNT_W-1:0]), 'h1234);

    // R4 software timer, R5 toggle on match, R6 square wave
    tick = 1'b0;
    put_cnt(0);
    put_cfg(0, 0, 0, 2); put_cmp(0, 'h20);
    put_cfg(1, 0, 0, 3); put_cmp(1, 'h30);
    put_cfg(2, 0, 0, 4); put_cmp(2, 'h4010);
    run(200, 1);
    check("R4", "swt output idle", int'(ch_out[0]), 0);
    flag_clr = 3'b111; cycle(); flag_clr = '0;
    run(300, 0);
    put_cnt('h2E);
    run(20, 1);
    check("R5", "toggle after second match", int'(ch_out[1]), 0);

    // R3 capture on rising / falling / both edges
    put_cfg(0, 0, 1, 1);
    put_cfg(1, 0, 2, 1);
    put_cfg(2, 0, 3, 1);
    for (int i = 0; i < 300; i++) begin
      cap_in = 3'($urandom);
      tick = 1'($urandom % 2);
      if (i % 50 == 0) flag_clr = 3'($urandom);
      cycle();
      flag_clr = '0;
    end
    cap_in = '0;
    run(3, 1);

    // R7/R8 PWM at 8, 11 and 16 bits, counter near the top for a full wrap (R2)
    tick = 1'b0;
    put_cfg(0, 0, 0, 5); put_cmp(0, 'h40);
    put_cfg(1, 3, 0, 5); put_cmp(1, 'h300);
    put_cfg(2, 4, 0, 5); put_cmp(2, 'h0100);
    put_cnt('hF000);
    run(1000, 1);
    put_cmp(0, 'hC0);   // R8: mid-period change takes effect next period
    put_cmp(1, 'h7F0);
    run(3600, 1);
    check("R2", "overflow after wrap", int'(ovf_flag), 1);

    // R7 PWM at 9 and 10 bits with irregular ticks
    put_cfg(0, 1, 0, 5); put_cmp(0, 'h150);
    put_cfg(1, 2, 0, 5); put_cmp(1, 'h05);
    run(5000, 0);

    // R2: clear colliding with a wrap keeps the flag set, plain clear drops it
    tick = 1'b0;
    put_cnt('hFFFF);
    tick = 1'b1; ovf_clr = 1'b1; cycle(); ovf_clr = 1'b0;
    check("R2", "wrap beats clear", int'(ovf_flag), 1);
    ovf_clr = 1'b1; cycle(); ovf_clr = 1'b0;
    check("R2", "plain clear", int'(ovf_flag), 0);

    // R9: config write drops output
    put_cfg(2, 0, 0, 3);
    check("R9", "config write clears output", int'(ch_out[2]), 0);
    run(20, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule